// File: doc/BRIEF.md
# All-Ones Alarm Detector

This block watches the two rails of a received bipolar line and raises an alarm when the line carries an all-ones (blue code) pattern. Time is cut into periods by an external window strobe. The strobe is asynchronous to the decode clock, so the block synchronizes it and treats each rising edge as the boundary between one period and the next.

Within a period the block counts received zeros. A zero is a cycle in which both rails are low. At every boundary it judges the period that just ended. If that period and the period before it each held fewer than three zeros, the alarm goes high. A single period with three or more zeros drops the alarm. In every other case the alarm keeps its value.

Top module: `ais_detector`

## Requirements
- R1: A cycle counts as a zero only when `rail_a` and `rail_b` are both low. One rail high, or both rails high, counts as a one.
- R2: A period holding 0, 1 or 2 zeros is a low-zero period. A low-zero period that follows a period with three or more zeros leaves the alarm low.
- R3: At a boundary, the alarm goes high when the period just ended and the period before it were both low-zero periods.
- R4: At a boundary, the alarm goes low when the period just ended held three or more zeros.
- R5: The alarm changes only as the result of a boundary or a reset. It stays high while every following period remains a low-zero period.
- R6: If the strobe is first sampled high at clock edge k, the rails sampled at edge k+2 are the first data of the new period, and the alarm takes its new value at edge k+2. Rails sampled at edges k and k+1 still belong to the old period.
- R7: With `rst_n` low at a clock edge, that edge clears the alarm, the zero count, the previous-period flag and the strobe synchronizer. The reset is synchronous and active low.
- R8: Only a rising edge of `win_strobe` ends a period. Holding the strobe high across what would be another period creates no boundary, and the zeros of both spans add into one period.
- R9: The zero count saturates. A period with any number of zeros at or above three, including every cycle, clears the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decode clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rail_a | input | 1 | Positive-pulse rail of the received line |
| rail_b | input | 1 | Negative-pulse rail of the received line |
| win_strobe | input | 1 | Asynchronous window strobe; a rising edge ends a period |
| alarm | output | 1 | All-ones alarm, active high |

## Verification
Two events can fall in the same cycle: the period boundary and the arrival of a zero. In that cycle the verdict must use the old count, while the zero opens the count of the new period. The bench provokes this by sweeping every placement of zeros in an 8-cycle window, which puts zeros in the two cycles before the boundary and in the first cycle after it. Each test window is interleaved with low-zero windows. The expected alarm is worked out from per-window zero totals, so a boundary that is off by one cycle moves a zero between windows and shows up as a wrong alarm.

// File: rtl/ais_pkg.sv
package ais_pkg;
    localparam int unsigned LOW_LIMIT = 3;
    localparam int unsigned CNT_W     = $clog2(LOW_LIMIT + 1);

    typedef logic [CNT_W-1:0] zcnt_t;

    localparam zcnt_t CNT_SAT = zcnt_t'(LOW_LIMIT);

    typedef struct packed {
        logic prev_low;
        logic alarm;
    } verdict_t;

    function automatic zcnt_t sat_inc(zcnt_t c, logic z);
        return (z && (c != CNT_SAT)) ? zcnt_t'(c + 1'b1) : c;
    endfunction

    function automatic logic is_low(zcnt_t c);
        return c < CNT_SAT;
    endfunction

    function automatic verdict_t judge(verdict_t cur, logic low);
        verdict_t n;
        n.prev_low = low;
        n.alarm    = low ? (cur.alarm | cur.prev_low) : 1'b0;
        return n;
    endfunction
endpackage

// File: rtl/ais_edge_sync.sv
module ais_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (!rst_n) sh[0] <= 1'b0;
        else        sh[0] <= async_in;
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) sh[i] <= 1'b0;
            else        sh[i] <= sh[i-1];
        end
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/ais_zero_counter.sv
module ais_zero_counter
    import ais_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  zero,
    input  logic  restart,
    output zcnt_t cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= zero ? zcnt_t'(1) : '0;
        else              cnt <= sat_inc(cnt, zero);
    end
endmodule

// File: rtl/ais_verdict.sv
module ais_verdict
    import ais_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  boundary,
    input  zcnt_t cnt,
    output logic  alarm,
    output logic  prev_low
);
    verdict_t st;

    always_ff @(posedge clk) begin
        if (!rst_n)        st <= '0;
        else if (boundary) st <= judge(st, is_low(cnt));
    end

    assign alarm    = st.alarm;
    assign prev_low = st.prev_low;
endmodule

// File: rtl/ais_detector.sv
module ais_detector
    import ais_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rail_a,
    input  logic rail_b,
    input  logic win_strobe,
    output logic alarm
);
    logic  zero;
    logic  boundary;
    logic  prev_low;
    zcnt_t zero_cnt;

    assign zero = ~(rail_a | rail_b);

    ais_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (win_strobe),
        .rise     (boundary)
    );

    ais_zero_counter cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .zero    (zero),
        .restart (boundary),
        .cnt     (zero_cnt)
    );

    ais_verdict vd_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (boundary),
        .cnt      (zero_cnt),
        .alarm    (alarm),
        .prev_low (prev_low)
    );
endmodule

// File: rtl/ais_detector_chk.sv
module ais_detector_chk
    import ais_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  zero,
    input logic  boundary,
    input zcnt_t zero_cnt,
    input logic  prev_low,
    input logic  alarm
);
    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && zero_cnt < CNT_SAT && prev_low) |=> alarm);

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && zero_cnt == CNT_SAT) |=> !alarm);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(alarm));

    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !zero) |=> (zero_cnt == '0));

    p_one_no_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!boundary && !zero) |=> $stable(zero_cnt));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!boundary && zero_cnt == CNT_SAT) |=> (zero_cnt == CNT_SAT));
endmodule

bind ais_detector ais_detector_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .zero     (zero),
    .boundary (boundary),
    .zero_cnt (zero_cnt),
    .prev_low (prev_low),
    .alarm    (alarm)
);

// File: tb/ais_detector_tb_top.sv
`timescale 1ns/1ps
module ais_detector_tb_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic rail_a = 1'b1;
    logic rail_b = 1'b0;
    logic win_strobe = 1'b0;
    logic alarm;

    int vectors = 0;
    int miscompares = 0;

    logic  exp_alarm = 1'b0;
    logic  exp_prev  = 1'b0;
    int    acc       = 0;
    string tag       = "R7";

    ais_detector dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rail_a     (rail_a),
        .rail_b     (rail_b),
        .win_strobe (win_strobe),
        .alarm      (alarm)
    );

    task automatic check(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s alarm actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rail_a = 1'b1; rail_b = 1'b0; win_strobe = 1'b0;
        repeat (3) @(negedge clk);
        check("R7", alarm, 1'b0);
        rst_n = 1'b1;
        exp_alarm = 1'b0; exp_prev = 1'b0; acc = 0; tag = "R7";
    endtask

    // zmask bit j = 1: zero in cycle j. smode 0 pulse at j6, 1 high from j6, 2 high all.
    // rot 3: every one is both rails high; otherwise rails rotate.
    task automatic run_window(input logic [7:0] zmask, input int smode,
                              input bit bnd, input int rot);
        logic low;
        logic old;
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            if (j == 1) check(tag, alarm, exp_alarm);
            if (zmask[j]) begin
                rail_a = 1'b0; rail_b = 1'b0;
            end else if (rot == 3) begin
                rail_a = 1'b1; rail_b = 1'b1;
            end else begin
                case ((j + rot) % 3)
                    0:       begin rail_a = 1'b1; rail_b = 1'b0; end
                    1:       begin rail_a = 1'b0; rail_b = 1'b1; end
                    default: begin rail_a = 1'b1; rail_b = 1'b1; end
                endcase
            end
            case (smode)
                0:       win_strobe = (j == 6);
                1:       win_strobe = (j >= 6);
                default: win_strobe = 1'b1;
            endcase
        end
        acc += $countones(zmask);
        if (bnd) begin
            low = (acc < 3);
            old = exp_alarm;
            exp_alarm = low ? (exp_alarm | exp_prev) : 1'b0;
            exp_prev  = low;
            if (!old && exp_alarm)      tag = "R3";
            else if (old && !exp_alarm) tag = (acc > 3) ? "R9" : "R4";
            else if (old)               tag = "R5";
            else                        tag = "R2";
            acc = 0;
        end else begin
            tag = "R8";
        end
    endtask

    initial begin
        #(5.0 * 200000);
        miscompares++;
        $display("FAIL watchdog expired alarm actual=%0b expected=%0b", alarm, exp_alarm);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        do_reset();

        // R1: both rails high is a one -> two clean windows raise the alarm
        run_window(8'h00, 0, 1'b1, 3);
        run_window(8'h00, 0, 1'b1, 3);
        run_window(8'h00, 0, 1'b1, 3);
        check("R1", alarm, 1'b1);

        // R6: zeros straddling the boundary (cycles 0,1,7) must clear
        run_window(8'b1000_0011, 0, 1'b1, 0);
        run_window(8'h00, 0, 1'b1, 0);
        check("R6", alarm, 1'b0);

        // R7: reset while alarm is high
        run_window(8'h01, 0, 1'b1, 1);
        run_window(8'h80, 0, 1'b1, 2);
        check("R3", alarm, 1'b1);
        do_reset();
        run_window(8'h00, 0, 1'b1, 0);

        // R8: strobe held high merges two spans into one period
        run_window(8'h01, 0, 1'b1, 0);
        run_window(8'h01, 1, 1'b1, 0);
        check("R3", alarm, 1'b1);
        run_window(8'h03, 2, 1'b0, 0);
        run_window(8'h02, 0, 1'b1, 0);
        run_window(8'h00, 0, 1'b1, 0);
        check("R8", alarm, 1'b0);

        // Sweep of every zero placement, interleaved with low windows
        for (int m = 0; m < 256; m++) begin
            run_window((m % 2) ? 8'h10 : 8'h00, 0, 1'b1, m % 3);
            run_window(8'(m), 0, 1'b1, (m + 1) % 4);
        end
        run_window(8'h00, 0, 1'b1, 0);
        run_window(8'hFF, 0, 1'b1, 0);
        run_window(8'h00, 0, 1'b1, 0);
        run_window(8'h00, 0, 1'b1, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule